// File: doc/BRIEF.md
# Polled Command Handshake Controller

This block sits on the device side of a small memory-mapped register bus. It lets a host start single-word transfers to or from a device port without interrupts. The host watches a busy flag, loads an outgoing word and a direction, and sets a command-ready flag. The controller raises busy and moves one word across a request/acknowledge device port. It then lowers command-ready together with the error flag, and lowers busy one cycle later. The host learns of completion only by reading the status register.

A host write that arrives while the controller is busy has no effect on the registers. Instead it sets a sticky overrun flag, which stays set until the next accepted command. A device that never acknowledges is abandoned after a programmable number of cycles, and the command ends with the error flag set. On a read command, the device word reaches the data-in register in the same cycle that busy clears.

Top module: `poll_cmd_ctrl`

## Requirements
- R1: After reset, every register reads zero: data-in (0x0), data-out (0x4), status (0x8) and control (0xC). The device request is low.
- R2: Data-out at 0x4 can be written and read back. Writes to data-in (0x0) and to status (0x8) change nothing.
- R3: A write to control (0xC) while busy is clear stores bit 1 as the direction (1 = write to device, 0 = read from device). If bit 0 of that write is 1, command-ready (status bit 0) reads 1 in the next cycle.
- R4: One cycle after command-ready is set, busy (status bit 1) rises. The device request is high only while busy is high.
- R5: During a write command, the device port carries the write direction and the data-out word.
- R6: A device acknowledge clears command-ready and error (status bit 2) in the next cycle, while busy stays high. Busy clears one cycle after that. Busy never falls in a cycle that follows one with command-ready high.
- R7: A read command loads the acknowledged device word into data-in in the same cycle that busy clears. A write command leaves data-in unchanged.
- R8: Writes to data-out or control while busy is high are ignored and set the overrun flag (status bit 3). The flag stays set until the next accepted command (a control write with bit 0 = 1 while busy is clear) clears it.
- R9: If TIMEOUT request cycles pass with no acknowledge, the command ends with error set, command-ready cleared and data-in unchanged, and busy clears one cycle later. An acknowledge in the last of those cycles counts as success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write access, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [3:2] pick the register |
| bus_wdata | input | DATA_W | Write data from the host |
| bus_rdata | output | DATA_W | Read data to the host |
| dev_req | output | 1 | Transfer request to the device |
| dev_write | output | 1 | Transfer direction, 1 = to device |
| dev_wdata | output | DATA_W | Word sent to the device |
| dev_ack | input | 1 | Device acknowledge for the current request |
| dev_rdata | input | DATA_W | Word returned by the device, sampled with dev_ack |

## Verification
Two events can land on the same clock edge: a host write that is refused because busy is high, and the device acknowledge that completes the transfer. The bench waits until it sees the acknowledge level on the device port, then places a data-out write on that same edge. It expects data-out to stay unchanged and overrun to be set. The read must still finish cleanly, with error clear and the device word in data-in. A second collision, between an acknowledge and the final timeout cycle, is provoked with an acknowledge delay of TIMEOUT-1. That command must end as a success.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

   typedef enum logic [1:0] {
      PCC_IDLE = 2'd0,
      PCC_XFER = 2'd1,
      PCC_DONE = 2'd2
   } pcc_state_e;

   // word index of each register (byte address bits [3:2])
   localparam logic [1:0] IDX_DIN  = 2'd0;
   localparam logic [1:0] IDX_DOUT = 2'd1;
   localparam logic [1:0] IDX_STAT = 2'd2;
   localparam logic [1:0] IDX_CTRL = 2'd3;

   // status bit positions
   localparam int unsigned ST_RDY  = 0;
   localparam int unsigned ST_BUSY = 1;
   localparam int unsigned ST_ERR  = 2;
   localparam int unsigned ST_OVR  = 3;

   // control bit positions
   localparam int unsigned CT_GO  = 0;
   localparam int unsigned CT_DIR = 1;

endpackage

// File: rtl/pcc_timer.sv
module pcc_timer #(
   parameter int unsigned TIMEOUT = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic ack_i,
   output logic expire_o
);
   localparam int unsigned CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

   logic [CNT_W-1:0] cnt_q;

   if (TIMEOUT < 2) begin : g_bad_timeout
      $error("pcc_timer: TIMEOUT must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run_i || ack_i) begin
         cnt_q <= '0;
      end else if (cnt_q != LAST) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expire_o = run_i && !ack_i && (cnt_q == LAST);

   // R9
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i) |=> (cnt_q == '0));

endmodule

// File: rtl/pcc_regfile.sv
module pcc_regfile
   import pcc_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 4,
   parameter bit          RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              busy_i,
   input  logic              fin_ok_i,
   input  logic              fin_err_i,
   input  logic              load_din_i,
   input  logic [DATA_W-1:0] din_val_i,
   output logic              cmd_ready_o,
   output logic              cmd_dir_o,
   output logic              err_o,
   output logic              ovr_o,
   output logic [DATA_W-1:0] data_out_o
);
   localparam int unsigned STAT_BITS = 4;
   localparam int unsigned CTRL_BITS = 2;

   if (DATA_W < STAT_BITS) begin : g_bad_width
      $error("pcc_regfile: DATA_W must hold the status field");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("pcc_regfile: ADDR_W must be at least 4");
   end

   logic [DATA_W-1:0] din_q, dout_q, rd_mux;
   logic              rdy_q, dir_q, err_q, ovr_q;
   logic [1:0]        widx;
   logic              wr_en, hit_dout, hit_ctrl, hit_din, blocked, accept_go;

   assign widx      = bus_addr[3:2];
   assign wr_en     = bus_sel && bus_wr;
   assign hit_dout  = wr_en && (widx == IDX_DOUT);
   assign hit_ctrl  = wr_en && (widx == IDX_CTRL);
   assign hit_din   = wr_en && (widx == IDX_DIN);
   assign blocked   = busy_i && (hit_dout || hit_ctrl);
   assign accept_go = hit_ctrl && !busy_i && bus_wdata[CT_GO];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= '0;
         dir_q  <= 1'b0;
      end else begin
         if (hit_dout && !busy_i) dout_q <= bus_wdata;
         if (hit_ctrl && !busy_i) dir_q  <= bus_wdata[CT_DIR];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_q <= 1'b0;
         err_q <= 1'b0;
         ovr_q <= 1'b0;
      end else begin
         if (accept_go)                  rdy_q <= 1'b1;
         else if (fin_ok_i || fin_err_i) rdy_q <= 1'b0;

         if (fin_err_i)     err_q <= 1'b1;
         else if (fin_ok_i) err_q <= 1'b0;

         if (blocked)        ovr_q <= 1'b1;
         else if (accept_go) ovr_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          din_q <= '0;
      else if (load_din_i) din_q <= din_val_i;
   end

   always_comb begin
      rd_mux = '0;
      unique case (widx)
         IDX_DIN:  rd_mux = din_q;
         IDX_DOUT: rd_mux = dout_q;
         IDX_STAT: rd_mux[STAT_BITS-1:0] = {ovr_q, err_q, busy_i, rdy_q};
         default:  rd_mux[CTRL_BITS-1:0] = {dir_q, rdy_q};
      endcase
   end

   if (RDATA_REG) begin : g_rd_flop
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  rd_q <= '0;
         else if (bus_sel && !bus_wr) rd_q <= rd_mux;
      end
      assign bus_rdata = rd_q;
   end else begin : g_rd_comb
      assign bus_rdata = rd_mux;
   end

   assign cmd_ready_o = rdy_q;
   assign cmd_dir_o   = dir_q;
   assign err_o       = err_q;
   assign ovr_o       = ovr_q;
   assign data_out_o  = dout_q;

   // R8
   busy_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_dout && busy_i) |=> ($stable(dout_q) && ovr_q));

   // R8
   busy_ctrl_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_ctrl && busy_i) |=> ($stable(dir_q) && ovr_q));

   // R2
   din_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_din && !load_din_i) |=> $stable(din_q));

   // R3
   go_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept_go |=> (rdy_q && !ovr_q));

endmodule

// File: rtl/pcc_fsm.sv
module pcc_fsm
   import pcc_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned TIMEOUT = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_ready_i,
   input  logic              cmd_dir_i,
   input  logic [DATA_W-1:0] data_out_i,
   output logic              busy_o,
   output logic              fin_ok_o,
   output logic              fin_err_o,
   output logic              load_din_o,
   output logic [DATA_W-1:0] din_val_o,
   output logic              dev_req_o,
   output logic              dev_write_o,
   output logic [DATA_W-1:0] dev_wdata_o,
   input  logic              dev_ack_i,
   input  logic [DATA_W-1:0] dev_rdata_i
);
   pcc_state_e        state_q;
   logic              busy_q, ok_q, expire;
   logic [DATA_W-1:0] hold_q;

   pcc_timer #(.TIMEOUT(TIMEOUT)) tmr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (dev_req_o),
      .ack_i    (dev_ack_i),
      .expire_o (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PCC_IDLE;
         busy_q  <= 1'b0;
         ok_q    <= 1'b0;
         hold_q  <= '0;
      end else begin
         unique case (state_q)
            PCC_IDLE: begin
               if (cmd_ready_i) begin
                  busy_q  <= 1'b1;
                  state_q <= PCC_XFER;
               end
            end
            PCC_XFER: begin
               if (dev_ack_i) begin
                  hold_q  <= dev_rdata_i;
                  ok_q    <= 1'b1;
                  state_q <= PCC_DONE;
               end else if (expire) begin
                  ok_q    <= 1'b0;
                  state_q <= PCC_DONE;
               end
            end
            default: begin
               busy_q  <= 1'b0;
               state_q <= PCC_IDLE;
            end
         endcase
      end
   end

   assign busy_o      = busy_q;
   assign dev_req_o   = (state_q == PCC_XFER);
   assign dev_write_o = cmd_dir_i;
   assign dev_wdata_o = data_out_i;
   assign fin_ok_o    = dev_req_o && dev_ack_i;
   assign fin_err_o   = expire;
   assign load_din_o  = (state_q == PCC_DONE) && ok_q && !cmd_dir_i;
   assign din_val_o   = hold_q;

   // R4
   busy_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(cmd_ready_i));

   // R4
   req_inside_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dev_req_o |-> busy_q);

   // R6
   ready_drops_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> !$past(cmd_ready_i));

   // R7
   din_load_at_busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_din_o |=> !busy_q);

endmodule

// File: rtl/poll_cmd_ctrl.sv
module poll_cmd_ctrl
   import pcc_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned TIMEOUT   = 256,
   parameter bit          RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              dev_req,
   output logic              dev_write,
   output logic [DATA_W-1:0] dev_wdata,
   input  logic              dev_ack,
   input  logic [DATA_W-1:0] dev_rdata
);
   logic              busy_w, fin_ok_w, fin_err_w, load_din_w;
   logic              rdy_w, dir_w, err_w, ovr_w;
   logic [DATA_W-1:0] din_val_w, dout_w;

   pcc_regfile #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .RDATA_REG (RDATA_REG)
   ) regs_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_sel     (bus_sel),
      .bus_wr      (bus_wr),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .busy_i      (busy_w),
      .fin_ok_i    (fin_ok_w),
      .fin_err_i   (fin_err_w),
      .load_din_i  (load_din_w),
      .din_val_i   (din_val_w),
      .cmd_ready_o (rdy_w),
      .cmd_dir_o   (dir_w),
      .err_o       (err_w),
      .ovr_o       (ovr_w),
      .data_out_o  (dout_w)
   );

   pcc_fsm #(
      .DATA_W  (DATA_W),
      .TIMEOUT (TIMEOUT)
   ) fsm_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_ready_i (rdy_w),
      .cmd_dir_i   (dir_w),
      .data_out_i  (dout_w),
      .busy_o      (busy_w),
      .fin_ok_o    (fin_ok_w),
      .fin_err_o   (fin_err_w),
      .load_din_o  (load_din_w),
      .din_val_o   (din_val_w),
      .dev_req_o   (dev_req),
      .dev_write_o (dev_write),
      .dev_wdata_o (dev_wdata),
      .dev_ack_i   (dev_ack),
      .dev_rdata_i (dev_rdata)
   );

   // R6
   ack_completion_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin_ok_w |=> (!err_w && !rdy_w && busy_w));

   // R9
   timeout_completion_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin_err_w |=> (err_w && !rdy_w && busy_w));

   // R8
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_w && !(bus_sel && bus_wr)) |=> ovr_w);

endmodule

// File: tb/poll_cmd_ctrl_tb_top.sv
module poll_cmd_ctrl_tb_top;
   localparam int DW = 32;
   localparam int AW = 4;
   localparam int TO = 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0, bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          dev_req, dev_write;
   logic [DW-1:0] dev_wdata;
   logic          dev_ack = 1'b0;
   logic [DW-1:0] dev_rdata = '0;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;
   int ack_delay = 0;
   int wcnt = 0;

   always #10ns clk = ~clk;

   poll_cmd_ctrl #(.DATA_W(DW), .ADDR_W(AW), .TIMEOUT(TO)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .dev_req   (dev_req),
      .dev_write (dev_write),
      .dev_wdata (dev_wdata),
      .dev_ack   (dev_ack),
      .dev_rdata (dev_rdata)
   );

   // device model: acknowledge after ack_delay request cycles; negative = never
   always @(negedge clk) begin
      if (dev_req && !dev_ack) begin
         if (ack_delay >= 0 && wcnt == ack_delay) dev_ack = 1'b1;
         else wcnt++;
      end else begin
         dev_ack = 1'b0;
         wcnt = 0;
      end
   end

   task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic peek(logic [AW-1:0] a, output logic [DW-1:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1ns;
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   // poll until busy clears; report busy cycles, data-in during last busy cycle
   task automatic poll(string req, output int nbusy, output logic [DW-1:0] din_last);
      logic [DW-1:0] st, last_st;
      nbusy = 0; last_st = '0; din_last = '0;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         peek(4'h8, st);
         if (!st[1]) break;
         nbusy++;
         last_st = st;
         peek(4'h0, din_last);
      end
      chk({req, " R6 ready low before busy falls"}, {31'd0, last_st[0]}, 32'd0);
   endtask

   task automatic t_reset();
      logic [DW-1:0] v;
      @(negedge clk);
      peek(4'h0, v); chk("R1 data-in", v, 0);
      peek(4'h4, v); chk("R1 data-out", v, 0);
      peek(4'h8, v); chk("R1 status", v, 0);
      peek(4'hC, v); chk("R1 control", v, 0);
      chk("R1 dev_req", {31'd0, dev_req}, 0);
   endtask

   task automatic t_regs();
      logic [DW-1:0] v;
      bus_write(4'h4, 32'hA5C3_0F1E);
      peek(4'h4, v); chk("R2 data-out readback", v, 32'hA5C3_0F1E);
      bus_write(4'h0, 32'hFFFF_FFFF);
      peek(4'h0, v); chk("R2 data-in read-only", v, 0);
      bus_write(4'h8, 32'hF);
      peek(4'h8, v); chk("R2 status read-only", v, 0);
   endtask

   task automatic t_write_cmd();
      logic [DW-1:0] v;
      ack_delay = 0;
      bus_write(4'h4, 32'h1357_9BDF);
      bus_write(4'hC, 32'h3);
      peek(4'h8, v); chk("R3 ready set", v, 32'h1);
      peek(4'hC, v); chk("R3 control dir", v, 32'h3);
      @(negedge clk);
      peek(4'h8, v); chk("R4 busy rises", v, 32'h3);
      chk("R4 request", {31'd0, dev_req}, 1);
      chk("R5 dev_write", {31'd0, dev_write}, 1);
      chk("R5 dev_wdata", dev_wdata, 32'h1357_9BDF);
      @(negedge clk);
      peek(4'h8, v); chk("R6 ready clears, busy held", v, 32'h2);
      @(negedge clk);
      peek(4'h8, v); chk("R6 busy clears", v, 32'h0);
      chk("R4 request gone", {31'd0, dev_req}, 0);
      peek(4'h0, v); chk("R7 write keeps data-in", v, 0);
   endtask

   task automatic t_read_cmd();
      logic [DW-1:0] v, dl;
      int nb;
      ack_delay = 3; dev_rdata = 32'h1234_5678;
      bus_write(4'hC, 32'h1);
      poll("read", nb, dl);
      chk("R7 busy cycles", nb, 5);
      chk("R7 data-in old during busy", dl, 0);
      peek(4'h0, v); chk("R7 data-in loaded", v, 32'h1234_5678);
      peek(4'h8, v); chk("R6 status clean", v, 0);
   endtask

   task automatic t_overrun();
      logic [DW-1:0] v, dl;
      int nb;
      ack_delay = 20; dev_rdata = 32'hCAFE_0001;
      bus_write(4'hC, 32'h1);
      @(negedge clk);
      bus_write(4'h4, 32'hDEAD_BEEF);
      peek(4'h4, v); chk("R8 data-out ignored", v, 32'h1357_9BDF);
      bus_write(4'hC, 32'h2);
      peek(4'hC, v); chk("R8 control ignored", v, 32'h1);
      peek(4'h8, v); chk("R8 overrun while busy", v, 32'hB);
      poll("overrun", nb, dl);
      peek(4'h8, v); chk("R8 overrun sticky", v, 32'h8);
      ack_delay = 0;
      bus_write(4'hC, 32'h3);
      peek(4'h8, v); chk("R8 overrun cleared by accept", v, 32'h1);
      poll("overrun2", nb, dl);
   endtask

   task automatic t_collision();
      logic [DW-1:0] v, dl;
      int nb;
      ack_delay = 2; dev_rdata = 32'h0BAD_F00D;
      bus_write(4'hC, 32'h1);
      for (int i = 0; i < 50; i++) begin
         @(negedge clk); #2ns;
         if (dev_ack) break;
      end
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h7777_7777;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      peek(4'h8, v); chk("R8 collision overrun, busy, ready low", v, 32'hA);
      peek(4'h4, v); chk("R8 collision data-out kept", v, 32'h1357_9BDF);
      poll("collision", nb, dl);
      peek(4'h8, v); chk("R6 collision no error", v, 32'h8);
      peek(4'h0, v); chk("R7 collision data-in", v, 32'h0BAD_F00D);
   endtask

   task automatic t_timeout();
      logic [DW-1:0] v, dl;
      int nb;
      ack_delay = -1; dev_rdata = 32'h5555_AAAA;
      bus_write(4'hC, 32'h1);
      poll("timeout", nb, dl);
      chk("R9 timeout busy cycles", nb, TO + 1);
      peek(4'h8, v); chk("R9 error set", v, 32'h4);
      peek(4'h0, v); chk("R9 data-in unchanged", v, 32'h0BAD_F00D);
      ack_delay = TO - 1; dev_rdata = 32'h0000_F1F1;
      bus_write(4'hC, 32'h1);
      poll("late ack", nb, dl);
      chk("R9 last-cycle ack busy cycles", nb, TO + 1);
      peek(4'h8, v); chk("R9 last-cycle ack is success", v, 32'h0);
      peek(4'h0, v); chk("R9 last-cycle ack data-in", v, 32'h0000_F1F1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_write_cmd();
      t_read_cmd();
      t_overrun();
      t_collision();
      t_timeout();
      finish_run();
   end

   initial begin
      #(20ns * 150000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

endmodule